// File: doc/BRIEF.md
# Asynchronous Serial Framer with Programmable Baud Prescaler

This block pairs a serial transmitter and a serial receiver that share one baud timebase. A two-bit clock-select input divides the system clock by 1, 4, 16 or 64. An 8-bit bit-rate divisor then counts those prescaled pulses to make a 16x oversampling tick. One serial bit lasts exactly sixteen ticks.

The transmitter takes a byte over a valid/ready port and sends a frame on a line that idles high. The frame is a low start bit, eight data bits with the least-significant bit first, an optional parity bit, and then one or two high stop bits. The receiver resynchronises the incoming line and waits for a falling edge. It confirms the start bit at its midpoint, then samples every later bit at its centre. Each rebuilt byte comes out as a one-cycle valid pulse with a parity-error flag and a framing-error flag.

A synchronous-mode input removes stop bits on both sides: the transmitter sends no stop bits and the receiver checks none. All configuration inputs are static while a frame is in flight.

Top module: `uart_framer`

## Requirements
- R1: `cfg_clk_sel` picks a prescale of 1 (00), 4 (01), 16 (10) or 64 (11) clock cycles. The oversampling tick period is prescale x (`cfg_divisor`+1) cycles, and one serial bit lasts 16 ticks.
- R2: The TX line is high whenever the transmitter is idle. A frame starts with one low bit and then sends the 8 data bits, least-significant bit first.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd`=0 the parity bit makes the count of ones over data and parity even; with 1 it makes that count odd. The receiver raises `rx_par_err` when the received parity breaks this rule.
- R4: In asynchronous mode, `cfg_two_stop`=0 appends one high stop bit and `cfg_two_stop`=1 appends two. `tx_ready` returns high only when the last stop bit ends.
- R5: A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both high. A valid pulse while a frame is in progress has no effect on the frame and starts no later frame.
- R6: If the RX line is high again at the midpoint of a detected start bit, reception is abandoned and no byte is produced.
- R7: The receiver rebuilds each byte least-significant bit first. It reports the byte with a `rx_valid` pulse exactly one cycle long.
- R8: `rx_frm_err` is 1 with the byte when the first stop bit samples low.
- R9: The receiver checks only the first stop bit, whatever `cfg_two_stop` says. A low bit right after a good first stop bit is taken as the start of the next byte, and no error is raised.
- R10: When `cfg_sync` is 1, no stop bits are sent and `cfg_two_stop` is ignored. The receiver reports the byte after the data bit (or the parity bit, when enabled) and never raises `rx_frm_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_sel | input | 2 | Prescaler select: 00 /1, 01 /4, 10 /16, 11 /64 |
| cfg_divisor | input | 8 | Bit-rate divisor; the tick comes every divisor+1 prescaled pulses |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_sync | input | 1 | 1 = frames carry no stop bits |
| tx_valid | input | 1 | Byte offered to the transmitter |
| tx_ready | output | 1 | Transmitter is idle and will take a byte |
| tx_data | input | 8 | Byte to send |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity mismatch on the reported byte |
| rx_frm_err | output | 1 | First stop bit of the reported byte sampled low |

## Verification
Loopback frames run with even parity, odd parity, no parity, one stop, two stops and synchronous mode. The bench checks each bit centre and the exact number of cycles until `tx_ready` returns, so a missing or extra parity or stop bit shows up. Three prescaler and divisor settings separate the four clock-select ratios through the frame length. Hand-driven RX frames cover wrong and right parity, a low first stop bit, a short start glitch, and two frames back to back with no second stop bit. A low line after the data in synchronous mode tells the stop-bit check apart from its absence.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

    localparam int OVS    = 16;
    localparam int TCNT_W = $clog2(OVS);
    localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(OVS - 1);
    localparam logic [TCNT_W-1:0] TCNT_MID  = TCNT_W'(OVS / 2 - 1);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_framer_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cfg_clk_sel,
    input  logic [DIV_W-1:0] cfg_divisor,
    output logic             tick
);

    localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
        logic [DIV_W-1:0] dcnt;
        logic             tick;
    } baud_s;

    baud_s            q, d;
    logic [PRE_W-1:0] mask;
    logic             pre_tick;

    always_comb begin
        mask = PRE_W'(({{PRE_W{1'b0}}, 1'b1} << {cfg_clk_sel, 1'b0}) - 1'b1);
        pre_tick = ((q.pcnt & mask) == mask);

        d        = q;
        d.pcnt   = q.pcnt + 1'b1;
        d.tick   = 1'b0;
        if (pre_tick) begin
            if (q.dcnt >= cfg_divisor) begin
                d.dcnt = '0;
                d.tick = 1'b1;
            end else begin
                d.dcnt = q.dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick = q.tick;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_clk_sel != '0 && $stable(cfg_clk_sel)) |=> !tick); // R1

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_framer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_sync,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              line
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [TCNT_W-1:0] tcnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              extra;
        logic              line;
    } tx_s;

    tx_s  q, d;
    logic payload_done;

    always_comb begin
        d            = q;
        payload_done = 1'b0;
        if (q.st == TX_IDLE) begin
            if (in_valid) begin
                d.st   = TX_START;
                d.sh   = in_data;
                d.par  = (^in_data) ^ cfg_par_odd;
                d.tcnt = '0;
                d.idx  = '0;
                d.line = 1'b0;
            end
        end else if (tick) begin
            d.tcnt = q.tcnt + 1'b1;
            if (q.tcnt == TCNT_LAST) begin
                case (q.st)
                    TX_START: begin
                        d.st   = TX_DATA;
                        d.line = q.sh[0];
                    end
                    TX_DATA: begin
                        if (q.idx == IDX_LAST) begin
                            if (cfg_par_en) begin
                                d.st   = TX_PAR;
                                d.line = q.par;
                            end else begin
                                payload_done = 1'b1;
                            end
                        end else begin
                            d.idx  = q.idx + 1'b1;
                            d.sh   = q.sh >> 1;
                            d.line = q.sh[1];
                        end
                    end
                    TX_PAR: payload_done = 1'b1;
                    TX_STOP: begin
                        if (q.extra) begin
                            d.extra = 1'b0;
                        end else begin
                            d.st = TX_IDLE;
                        end
                    end
                    default: d.st = TX_IDLE;
                endcase
            end
        end

        if (payload_done) begin
            d.line  = 1'b1;
            d.extra = cfg_two_stop;
            d.st    = cfg_sync ? TX_IDLE : TX_STOP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.st == TX_IDLE);
    assign line     = q.line;

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> line); // R2

    AST_TX_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !line)); // R5

    AST_TX_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !tick) |=> $stable(line)); // R1

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_framer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_sync,
    input  logic              line_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_par_err,
    output logic              out_frm_err
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              prev;
        rx_state_e         st;
        logic [TCNT_W-1:0] tcnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              vld;
        logic [DATA_W-1:0] dat;
        logic              perr;
        logic              ferr;
    } rx_s;

    rx_s  q, d;
    logic payload_done;
    logic emit;
    logic emit_ferr;

    always_comb begin
        d            = q;
        d.s1         = line_in;
        d.s2         = q.s1;
        d.prev       = q.s2;
        d.vld        = 1'b0;
        payload_done = 1'b0;
        emit         = 1'b0;
        emit_ferr    = 1'b0;

        case (q.st)
            RX_IDLE: begin
                d.tcnt = '0;
                if (q.prev && !q.s2) begin
                    d.st = RX_START;
                end
            end
            RX_START: begin
                if (tick) begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (q.tcnt == TCNT_MID) begin
                        if (q.s2) begin
                            d.st = RX_IDLE;
                        end else begin
                            d.st   = RX_DATA;
                            d.tcnt = '0;
                            d.idx  = '0;
                            d.par  = 1'b0;
                            d.perr = 1'b0;
                        end
                    end
                end
            end
            default: begin
                if (tick) begin
                    d.tcnt = q.tcnt + 1'b1;
                    if (q.tcnt == TCNT_LAST) begin
                        case (q.st)
                            RX_DATA: begin
                                d.sh  = {q.s2, q.sh[DATA_W-1:1]};
                                d.par = q.par ^ q.s2;
                                d.idx = q.idx + 1'b1;
                                if (q.idx == IDX_LAST) begin
                                    if (cfg_par_en) begin
                                        d.st = RX_PAR;
                                    end else begin
                                        payload_done = 1'b1;
                                    end
                                end
                            end
                            RX_PAR: begin
                                d.perr       = q.par ^ q.s2 ^ cfg_par_odd;
                                payload_done = 1'b1;
                            end
                            RX_STOP: begin
                                emit      = 1'b1;
                                emit_ferr = !q.s2;
                            end
                            default: d.st = RX_IDLE;
                        endcase
                    end
                end
            end
        endcase

        if (payload_done) begin
            if (cfg_sync) begin
                emit = 1'b1;
            end else begin
                d.st = RX_STOP;
            end
        end

        if (emit) begin
            d.st   = RX_IDLE;
            d.vld  = 1'b1;
            d.dat  = d.sh;
            d.ferr = emit_ferr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.vld;
    assign out_data    = q.dat;
    assign out_par_err = q.perr;
    assign out_frm_err = q.ferr;

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R7

    AST_RX_SYNC_NO_FRAME_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_sync)) |-> !out_frm_err); // R10

endmodule

// File: rtl/uart_framer.sv
module uart_framer
    import uart_framer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_sync,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_line,
    input  logic              rx_line,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err
);

    logic tick;

    uart_baud_gen #(
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) u_baud (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_clk_sel (cfg_clk_sel),
        .cfg_divisor (cfg_divisor),
        .tick        (tick)
    );

    uart_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cfg_two_stop (cfg_two_stop),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_sync     (cfg_sync),
        .in_valid     (tx_valid),
        .in_ready     (tx_ready),
        .in_data      (tx_data),
        .line         (tx_line)
    );

    uart_rx #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_sync    (cfg_sync),
        .line_in     (rx_line),
        .out_valid   (rx_valid),
        .out_data    (rx_data),
        .out_par_err (rx_par_err),
        .out_frm_err (rx_frm_err)
    );

endmodule

// File: tb/test_uart_framer.sv
`timescale 1ns/1ps
module test_uart_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_clk_sel = 2'b00;
    logic [7:0] cfg_divisor = 8'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_sync = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic       tx_line;
    logic       rx_line;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_par_err;
    logic       rx_frm_err;

    logic       loop_en = 1'b1;
    logic       rx_drv = 1'b1;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic       prev_vld = 1'b0;
    logic [9:0] rx_q[$];

    always #10 clk = ~clk;

    assign rx_line = loop_en ? tx_line : rx_drv;

    uart_framer i_uart_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_clk_sel  (cfg_clk_sel),
        .cfg_divisor  (cfg_divisor),
        .cfg_two_stop (cfg_two_stop),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_sync     (cfg_sync),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_line      (tx_line),
        .rx_line      (rx_line),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_par_err   (rx_par_err),
        .rx_frm_err   (rx_frm_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Every-clock model: idle line high, received pulse one cycle long.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tx_ready && !tx_line) chk(1'b0, "R2", "line low while idle", 0, 1);
            if (rx_valid && prev_vld) chk(1'b0, "R7", "valid longer than one cycle", 2, 1);
            if (rx_valid) rx_q.push_back({rx_frm_err, rx_par_err, rx_data});
            prev_vld = rx_valid;
        end
    end

    // Send one byte, sample every bit centre, time the return of ready.
    task automatic send_tx(input logic [7:0] b, input int bit_clks, input int nstop,
                           input bit poke, input string req);
        logic [15:0] exp_bits = '0;
        logic [15:0] act_bits = '0;
        int n = 9;
        int got = -1;
        int lo;
        bit idle_ok = 1'b1;
        exp_bits[8:1] = b;
        if (cfg_par_en) begin
            exp_bits[n] = (^b) ^ cfg_par_odd;
            n++;
        end
        for (int s = 0; s < nstop; s++) begin
            exp_bits[n] = 1'b1;
            n++;
        end
        while (!tx_ready) @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k < n * bit_clks + 3 * bit_clks; k++) begin
            if (k % bit_clks == bit_clks / 2 && k / bit_clks < n) act_bits[k / bit_clks] = tx_line;
            if (k >= n * bit_clks && !tx_line) idle_ok = 1'b0;
            if (tx_ready && got < 0) got = k;
            if (poke && k == 3 * bit_clks) begin
                tx_data  = ~b;
                tx_valid = 1'b1;
            end
            if (poke && k == 3 * bit_clks + 1) tx_valid = 1'b0;
            @(negedge clk);
        end
        lo = n * bit_clks - (bit_clks / 16 - 1);
        chk(act_bits == exp_bits, req, "frame bits", int'(act_bits), int'(exp_bits));
        chk(got >= lo && got <= n * bit_clks, req, "cycles until ready", got, n * bit_clks);
        chk(idle_ok, req, "line idle after frame", 0, 1);
    endtask

    task automatic drive_rx(input logic [15:0] bits, input int n, input int bit_clks);
        for (int i = 0; i < n; i++) begin
            rx_drv = bits[i];
            repeat (bit_clks) @(negedge clk);
        end
        rx_drv = 1'b1;
    endtask

    task automatic expect_rx(input logic [7:0] b, input bit perr, input bit ferr,
                             input string req);
        logic [9:0] e;
        chk(rx_q.size() > 0, req, "byte received", rx_q.size(), 1);
        if (rx_q.size() > 0) begin
            e = rx_q.pop_front();
            chk(e == {ferr, perr, b}, req, "received {ferr,perr,data}", int'(e),
                int'({ferr, perr, b}));
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R2: reset state
        chk(tx_line == 1'b1, "R2", "tx_line in reset", tx_line, 1);
        chk(tx_ready == 1'b1, "R2", "tx_ready in reset", tx_ready, 1);
        chk(rx_valid == 1'b0, "R7", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 / R7: plain frame in loopback, one stop bit
        send_tx(8'hA5, 16, 1, 1'b0, "R2");
        expect_rx(8'hA5, 1'b0, 1'b0, "R7");

        // R3: even then odd parity
        cfg_par_en = 1'b1;
        send_tx(8'h5B, 16, 1, 1'b0, "R3");
        expect_rx(8'h5B, 1'b0, 1'b0, "R3");
        cfg_par_odd = 1'b1;
        send_tx(8'h5B, 16, 1, 1'b0, "R3");
        expect_rx(8'h5B, 1'b0, 1'b0, "R3");
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R4: two stop bits
        cfg_two_stop = 1'b1;
        send_tx(8'hC3, 16, 2, 1'b0, "R4");
        expect_rx(8'hC3, 1'b0, 1'b0, "R4");

        // R10: synchronous mode drops stop bits despite two-stop setting
        cfg_sync = 1'b1;
        send_tx(8'h35, 16, 0, 1'b0, "R10");
        expect_rx(8'h35, 1'b0, 1'b0, "R10");
        cfg_sync = 1'b0;
        cfg_two_stop = 1'b0;
        repeat (32) @(negedge clk);

        // R5: valid during a frame is ignored
        send_tx(8'h3C, 16, 1, 1'b1, "R5");
        expect_rx(8'h3C, 1'b0, 1'b0, "R5");
        chk(rx_q.size() == 0, "R5", "no second frame", rx_q.size(), 0);

        // Receiver tests with a driven line
        loop_en = 1'b0;
        repeat (32) @(negedge clk);
        cfg_par_en = 1'b1;
        drive_rx({5'b11111, 1'b1, 1'b1, 8'h0F, 1'b0}, 11, 16);  // R3 bad parity
        repeat (16) @(negedge clk);
        expect_rx(8'h0F, 1'b1, 1'b0, "R3");
        drive_rx({5'b11111, 1'b1, 1'b0, 8'h0F, 1'b0}, 11, 16);  // R3 good parity
        repeat (16) @(negedge clk);
        expect_rx(8'h0F, 1'b0, 1'b0, "R3");
        cfg_par_en = 1'b0;

        // R8: low first stop bit
        drive_rx({6'b000000, 1'b0, 8'h69, 1'b0}, 10, 16);
        repeat (32) @(negedge clk);
        expect_rx(8'h69, 1'b0, 1'b1, "R8");

        // R6: short start glitch
        rx_drv = 1'b0;
        repeat (4) @(negedge clk);
        rx_drv = 1'b1;
        repeat (12 * 16) @(negedge clk);
        chk(rx_q.size() == 0, "R6", "glitch produced no byte", rx_q.size(), 0);
        drive_rx({6'b111111, 1'b1, 8'h81, 1'b0}, 10, 16);
        repeat (16) @(negedge clk);
        expect_rx(8'h81, 1'b0, 1'b0, "R6");

        // R9: second frame starts right after one stop bit
        cfg_two_stop = 1'b1;
        drive_rx({6'b111111, 1'b1, 8'h4D, 1'b0}, 10, 16);
        drive_rx({6'b111111, 1'b1, 8'hB2, 1'b0}, 10, 16);
        repeat (16) @(negedge clk);
        expect_rx(8'h4D, 1'b0, 1'b0, "R9");
        expect_rx(8'hB2, 1'b0, 1'b0, "R9");
        cfg_two_stop = 1'b0;

        // R10: synchronous mode does not check a stop bit
        cfg_sync = 1'b1;
        drive_rx({6'b000000, 1'b0, 8'h35, 1'b0}, 10, 16);
        repeat (16) @(negedge clk);
        expect_rx(8'h35, 1'b0, 1'b0, "R10");
        cfg_sync = 1'b0;
        repeat (32) @(negedge clk);

        // R1: prescaler and divisor settings, loopback
        loop_en = 1'b1;
        cfg_clk_sel = 2'b01;
        cfg_divisor = 8'd1;
        send_tx(8'h96, 128, 1, 1'b0, "R1");
        expect_rx(8'h96, 1'b0, 1'b0, "R1");
        cfg_clk_sel = 2'b10;
        cfg_divisor = 8'd2;
        send_tx(8'h2E, 768, 1, 1'b0, "R1");
        expect_rx(8'h2E, 1'b0, 1'b0, "R1");
        cfg_clk_sel = 2'b11;
        cfg_divisor = 8'd0;
        send_tx(8'h71, 1024, 1, 1'b0, "R1");
        expect_rx(8'h71, 1'b0, 1'b0, "R1");

        summary();
    end

endmodule